// File: doc/BRIEF.md
# Dual-Mixer Beat Edge Timestamper

This block is the digital back end of a dual-mixer time-difference phase detector. A clock under test enters on `test_clk_in` and is captured by a plain D flip-flop clocked by a slightly offset reference. That flip-flop acts as a digital mixer, and its output is a slow beat square wave. The sampled bit passes through a short synchroniser chain that absorbs metastability. The block then locates each falling beat transition and timestamps it with a 32-bit free-running counter that runs on the same reference clock.

Sampler noise produces a burst of glitches around every beat transition, so the first change seen is a poor estimate of the edge. The block first waits for a long run of high samples, which marks a quiet zone. It then opens a fixed window at the first low sample and counts how the samples inside that window split between high and low. The reported time is the window start moved later by the number of high samples that remain inside the window. This balance point follows the median of the noisy crossing. After each report the block waits for a long run of low samples before it arms again, so each transition yields exactly one timestamp. Results queue in a small first-word-fall-through buffer that a consumer drains.

Top module: `ddmtd_edge_stamper`

## Requirements
- R1: After reset, `ts_valid` and `overflow` are both low.
- R2: The stamp of a sample is the number of rising clock edges since reset was released, counted before the edge that captures that sample (modulo 2^32). For a clean falling beat edge after arming, the queued value equals the stamp of the first low sample. The value enters the queue on the third rising edge after the edge that captures the last window sample.
- R3: The window covers 32 samples, starting at the first low sample after arming. The queued value is the stamp of that first low sample plus the count of high samples inside the window, including a high sample in the window's last position.
- R4: Arming requires 64 consecutive high samples. After only 63 high samples, a falling transition produces no timestamp.
- R5: After a window closes, every transition is ignored until 64 consecutive low samples have been seen. Rising transitions never produce a timestamp. Once that low run completes, 64 high samples arm the block again.
- R6: The queue holds 16 entries and presents the oldest on `ts_data` while `ts_valid` is high. `rd_en` high on a clock edge with `ts_valid` high removes that entry, and entries leave in arrival order.
- R7: A timestamp that arrives while the queue is full, with no removal on the same edge, is dropped. The stored entries stay unchanged, and `overflow` goes high and stays high until reset.
- R8: `rd_en` while the queue is empty has no effect. The next timestamp is presented correctly and as the only entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Offset reference clock; clocks the mixer flip-flop, counter and logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| test_clk_in | input | 1 | Clock under test, sampled by the mixer flip-flop |
| rd_en | input | 1 | Remove the head entry of the timestamp queue |
| ts_valid | output | 1 | Queue holds at least one timestamp |
| ts_data | output | 32 | Oldest queued timestamp |
| overflow | output | 1 | Sticky flag: a timestamp was dropped because the queue was full |

## Verification
A sample driven before rising edge m, where m is the edge that captures the last window sample, crosses three registers: the mixer and two synchroniser stages. The state machine therefore acts on it at edge m+3, and the queue write happens on that same edge. The bench checks `ts_valid` at the falling edge after m+2 and expects it low, then at the falling edge after m+3 and expects it high, so the latency is pinned to the exact cycle. The bench stamps each sample with its own edge count taken at the falling edge where it drives that sample, so expected values come from the stimulus alone. Queue and overflow results are sampled on falling edges after the settle interval, by which time every write has landed.

// File: rtl/ddmtd_pkg.sv
package ddmtd_pkg;

  // Phases of the beat-edge estimator
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,  // counting a run of high samples toward arming
    ST_ARMED  = 2'd1,  // quiet high zone reached, waiting for the first low
    ST_WINDOW = 2'd2,  // accumulating high samples inside the window
    ST_SETTLE = 2'd3   // waiting for a long low run before hunting again
  } edge_state_e;

  // Pointer advance with wrap for a queue of arbitrary depth
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/ddmtd_sampler.sv
module ddmtd_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_in,
  output logic bit_out
);

  logic                   mix_q;
  logic [SYNC_STAGES-1:0] sync_q;

  // Digital mixer: the clock under test is captured by the offset reference
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mix_q <= 1'b0;
    else        mix_q <= test_in;
  end

  // Resynchronising chain, one register per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= mix_q;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign bit_out = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ddmtd_median_fsm.sv
module ddmtd_median_fsm
  import ddmtd_pkg::*;
#(
  parameter int TS_W     = 32,
  parameter int SAFE_LEN = 64,
  parameter int WIN_LEN  = 32,
  parameter int LAT      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_in,
  input  logic [TS_W-1:0] tcnt,
  output logic            push,
  output logic [TS_W-1:0] stamp
);

  localparam int RUN_W = (SAFE_LEN > 1) ? $clog2(SAFE_LEN) : 1;
  localparam int WIN_W = $clog2(WIN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SAFE_LEN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [TS_W-1:0]  LAT_TS   = TS_W'(LAT);

  edge_state_e      state_q, state_d;
  logic [RUN_W-1:0] run_q,   run_d;
  logic [WIN_W-1:0] win_q,   win_d;
  logic [WIN_W-1:0] ones_q,  ones_d;
  logic [TS_W-1:0]  t0_q,    t0_d;
  logic             t0_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    win_d   = win_q;
    ones_d  = ones_q;
    t0_d    = t0_q;
    t0_en   = 1'b0;
    push    = 1'b0;
    stamp   = t0_q + TS_W'(ones_q) + TS_W'(bit_in);

    unique case (state_q)
      ST_HUNT: begin
        if (bit_in) begin
          if (run_q == RUN_LAST) begin
            state_d = ST_ARMED;
            run_d   = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end

      ST_ARMED: begin
        if (!bit_in) begin
          // First low sample: its capture time is the counter minus the pipe depth
          state_d = ST_WINDOW;
          t0_en   = 1'b1;
          t0_d    = tcnt - LAT_TS;
          ones_d  = '0;
          win_d   = WIN_W'(1);
        end
      end

      ST_WINDOW: begin
        if (win_q == WIN_LAST) begin
          push    = 1'b1;
          state_d = ST_SETTLE;
          run_d   = '0;
        end else begin
          ones_d = ones_q + WIN_W'(bit_in);
          win_d  = win_q + 1'b1;
        end
      end

      ST_SETTLE: begin
        if (!bit_in) begin
          if (run_q == RUN_LAST) begin
            state_d = ST_HUNT;
            run_d   = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end

      default: state_d = ST_HUNT;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      win_q   <= '0;
      ones_q  <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      win_q   <= win_d;
      ones_q  <= ones_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     t0_q <= '0;
    else if (t0_en) t0_q <= t0_d;
  end

endmodule

// File: rtl/ddmtd_stamp_fifo.sv
module ddmtd_stamp_fifo
  import ddmtd_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_data,
  input  logic            rd_en,
  output logic            valid,
  output logic [TS_W-1:0] rd_data,
  output logic            overflow
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [TS_W-1:0]  mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q,    cnt_d;
  logic             ovf_q,    ovf_d;
  logic             do_pop, do_push;

  always_comb begin
    do_pop   = rd_en && (cnt_q != '0);
    do_push  = wr_en && ((cnt_q != CNT_FULL) || do_pop);
    wr_ptr_d = do_push ? AW'(wrap_inc(int'(wr_ptr_q), DEPTH)) : wr_ptr_q;
    rd_ptr_d = do_pop  ? AW'(wrap_inc(int'(rd_ptr_q), DEPTH)) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    ovf_d    = ovf_q || (wr_en && !do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  // Storage carries no reset; validity comes from the count
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wr_data;
  end

  assign valid    = (cnt_q != '0);
  assign rd_data  = mem[rd_ptr_q];
  assign overflow = ovf_q;

endmodule

// File: rtl/ddmtd_edge_stamper.sv
module ddmtd_edge_stamper #(
  parameter int TS_W        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SAFE_LEN    = 64,
  parameter int WIN_LEN     = 32,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_clk_in,
  input  logic            rd_en,
  output logic            ts_valid,
  output logic [TS_W-1:0] ts_data,
  output logic            overflow
);

  // Registers between the pin and the estimator: mixer plus synchroniser
  localparam int LAT = SYNC_STAGES + 1;

  logic            s_bit;
  logic [TS_W-1:0] tcnt, tcnt_d;
  logic            push;
  logic [TS_W-1:0] stamp;

  // Free-running timestamp counter
  assign tcnt_d = tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt_d;
  end

  ddmtd_sampler #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .test_in (test_clk_in),
    .bit_out (s_bit)
  );

  ddmtd_median_fsm #(
    .TS_W     (TS_W),
    .SAFE_LEN (SAFE_LEN),
    .WIN_LEN  (WIN_LEN),
    .LAT      (LAT)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (s_bit),
    .tcnt   (tcnt),
    .push   (push),
    .stamp  (stamp)
  );

  ddmtd_stamp_fifo #(
    .TS_W  (TS_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push),
    .wr_data  (stamp),
    .rd_en    (rd_en),
    .valid    (ts_valid),
    .rd_data  (ts_data),
    .overflow (overflow)
  );

endmodule

// File: rtl/ddmtd_edge_stamper_chk.sv
module ddmtd_edge_stamper_chk #(
  parameter int TS_W     = 32,
  parameter int SAFE_LEN = 64,
  parameter int WIN_LEN  = 32,
  parameter int LAT      = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push,
  input logic [TS_W-1:0] stamp,
  input logic [TS_W-1:0] tcnt,
  input logic            rd_en,
  input logic            ts_valid,
  input logic [TS_W-1:0] ts_data,
  input logic            overflow
);

  localparam int MIN_GAP = 2 * SAFE_LEN + WIN_LEN;
  localparam int GAP_W   = $clog2(MIN_GAP + 1);

  logic [TS_W-1:0]  lag;
  logic [GAP_W-1:0] gap_q;

  assign lag = tcnt - stamp;

  // Edges since the previous write, saturating at the required minimum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_q <= GAP_W'(MIN_GAP);
    else if (push)                      gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(MIN_GAP))   gap_q <= gap_q + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!ts_valid && !overflow));

  p_stamp_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((lag >= TS_W'(LAT)) && (lag <= TS_W'(LAT + WIN_LEN - 1))));

  p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (gap_q >= GAP_W'(MIN_GAP)));

  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !rd_en) |=> (ts_valid && $stable(ts_data)));

  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_overflow_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(push && ts_valid && !rd_en));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts_valid && !push) |=> !ts_valid);

endmodule

bind ddmtd_edge_stamper ddmtd_edge_stamper_chk #(
  .TS_W     (TS_W),
  .SAFE_LEN (SAFE_LEN),
  .WIN_LEN  (WIN_LEN),
  .LAT      (SYNC_STAGES + 1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push     (push),
  .stamp    (stamp),
  .tcnt     (tcnt),
  .rd_en    (rd_en),
  .ts_valid (ts_valid),
  .ts_data  (ts_data),
  .overflow (overflow)
);

// File: tb/ddmtd_edge_stamper_tb.sv
module ddmtd_edge_stamper_tb;

  localparam int TS_W  = 32;
  localparam int SAFE  = 64;
  localparam int WIN   = 32;
  localparam int DEPTH = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            test_in = 1'b0;
  logic            rd_en = 1'b0;
  logic            ts_valid;
  logic [TS_W-1:0] ts_data;
  logic            overflow;

  int unsigned     cyc = 0;
  int              checks = 0;
  int              fails = 0;
  logic [TS_W-1:0] last_stamp;
  logic [TS_W-1:0] exp_q [DEPTH];

  always #5 clk = ~clk;

  // Bench edge count since reset release; read only on falling edges
  always @(posedge clk) if (rst_n) cyc++;

  ddmtd_edge_stamper u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_clk_in (test_in),
    .rd_en       (rd_en),
    .ts_valid    (ts_valid),
    .ts_data     (ts_data),
    .overflow    (overflow)
  );

  task automatic check_eq(input string req, input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    @(negedge clk);
    test_in    = b;
    last_stamp = cyc;
  endtask

  task automatic run(input logic b, input int n);
    for (int i = 0; i < n; i++) drive(b);
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [TS_W-1:0] exp);
    check_eq(req, TS_W'(ts_valid), TS_W'(1));
    check_eq(req, ts_data, exp);
    pop();
  endtask

  // Armed clean falling edge, then a full settle; returns the first-low stamp
  task automatic clean_edge(output logic [TS_W-1:0] s0);
    run(1'b1, SAFE + 6);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b0, WIN - 1);
    run(1'b0, SAFE + 8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_eq("R1 valid", TS_W'(ts_valid), 0);
    check_eq("R1 overflow", TS_W'(overflow), 0);
    run(1'b0, 4);
    check_eq("R1 valid held", TS_W'(ts_valid), 0);
  endtask

  task automatic t_clean();
    logic [TS_W-1:0] s0;
    run(1'b1, SAFE + 6);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b0, WIN - 1);
    run(1'b0, 3);
    check_eq("R2 not yet written", TS_W'(ts_valid), 0);
    drive(1'b0);
    check_eq("R2 written at edge m+3", TS_W'(ts_valid), 1);
    expect_head("R2 clean stamp", s0);
    check_eq("R2 single entry", TS_W'(ts_valid), 0);
    run(1'b0, SAFE + 8);
  endtask

  task automatic t_glitch();
    logic [TS_W-1:0] s0;
    logic [WIN-2:0]  pat;
    // Glitches near the crossing and one in the window's last slot: 5 highs
    pat = '0;
    pat[0] = 1'b1; pat[1] = 1'b1; pat[3] = 1'b1; pat[6] = 1'b1; pat[WIN-2] = 1'b1;
    run(1'b1, SAFE + 6);
    drive(1'b0);
    s0 = last_stamp;
    for (int i = 0; i < WIN - 1; i++) drive(pat[i]);
    run(1'b0, SAFE + 8);
    expect_head("R3 glitch pattern", s0 + 5);
    // Second pattern: only the first window sample low
    run(1'b1, SAFE + 6);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b1, WIN - 1);
    run(1'b0, SAFE + 8);
    expect_head("R3 late crossing", s0 + WIN - 1);
  endtask

  task automatic t_arm();
    logic [TS_W-1:0] s0;
    run(1'b1, SAFE - 1);
    run(1'b0, WIN + 10);
    check_eq("R4 63 highs do not arm", TS_W'(ts_valid), 0);
    run(1'b1, SAFE);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b0, WIN - 1);
    run(1'b0, SAFE + 8);
    expect_head("R4 64 highs arm", s0);
  endtask

  task automatic t_settle();
    logic [TS_W-1:0] s0;
    run(1'b1, SAFE + 6);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b0, WIN - 1);
    run(1'b1, 80);
    run(1'b0, 10);
    run(1'b1, 5);
    run(1'b0, 50);
    expect_head("R5 one stamp per crossing", s0);
    check_eq("R5 no extra stamp", TS_W'(ts_valid), 0);
    run(1'b0, 30);
    run(1'b1, SAFE);
    drive(1'b0);
    s0 = last_stamp;
    run(1'b0, WIN - 1);
    run(1'b0, SAFE + 8);
    expect_head("R5 rearm after low run", s0);
  endtask

  task automatic t_fifo();
    logic [TS_W-1:0] s0;
    for (int i = 0; i < DEPTH; i++) clean_edge(exp_q[i]);
    check_eq("R7 no overflow at exactly full", TS_W'(overflow), 0);
    check_eq("R6 full queue valid", TS_W'(ts_valid), 1);
    clean_edge(s0);
    check_eq("R7 overflow on drop", TS_W'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) expect_head("R6 order", exp_q[i]);
    check_eq("R6 drained", TS_W'(ts_valid), 0);
    @(negedge clk);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    check_eq("R8 empty read", TS_W'(ts_valid), 0);
    clean_edge(s0);
    expect_head("R8 after empty read", s0);
    check_eq("R8 single entry", TS_W'(ts_valid), 0);
    check_eq("R7 overflow sticky", TS_W'(overflow), 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_glitch();
    t_arm();
    t_settle();
    t_fifo();
    summary();
    $finish;
  end

endmodule